// File: doc/BRIEF.md
# Coin-Accumulating Vend Controller

This block is a small synchronous controller for a single-product vending slot. Every clock cycle it may receive one coin event on a 2-bit coded input (nickel, dime or quarter, or no coin). It keeps the running credit of the current purchase in nickel units, so the held credit is always 0, 5, 10 or 15 cents.

The outputs are combinational functions of the held credit and the coin now on the input. When the held credit plus the coin value reaches 20 cents or more, the controller raises its vend output in that same cycle. It also reports the change owed as a count of nickels. At the next clock edge it clears the credit to zero, ready for the next customer. A quarter always crosses the threshold, whatever the credit, so the change is worked out from the credit before the coin plus the coin value.

Top module: `vend_ctrl`

## Requirements
- R1: The coin input uses the code 2'b00 for no coin, 2'b01 for a nickel (5 cents), 2'b10 for a dime (10 cents) and 2'b11 for a quarter (25 cents).
- R2: While the credit plus the incoming coin stays below 20 cents, the coin's value is added to the held credit at the clock edge, and vend and change stay at zero.
- R3: In the cycle where the held credit plus the incoming coin reaches or passes 20 cents, vend is 1 in that same cycle, with no extra register delay.
- R4: The change output is a count of nickels equal to (credit + coin − 20 cents) / 5, valid in the vend cycle; its range is 0 to 4.
- R5: After a vend cycle the held credit is zero, so the next transaction starts from nothing.
- R6: A no-coin code leaves the credit unchanged and drives vend and change to zero.
- R7: While the synchronous reset is high, vend and change are zero whatever the coin input is, and at the clock edge the credit is cleared to zero.
- R8: Vend lasts exactly one cycle per crossing, and change is nonzero only in a cycle where vend is 1.
- R9: A quarter vends from any credit; from 15 cents of credit it gives the largest change, 4 nickels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_i | input | 2 | Coded coin event for this cycle |
| vend_o | output | 1 | Dispense pulse, high during the crossing cycle |
| change_o | output | 3 | Change owed in nickels, valid while vend_o is high |

## Verification
The assertions check on every clock that a quarter always vends and that no-coin cycles and reset cycles are silent. They also check that change never appears without vend, that change never exceeds four nickels, and that the credit is zero in the cycle after a vend. How the credit builds up over mixed coin sequences cannot be seen from one cycle alone. This covers which exact cycle crosses the threshold, the change value for each starting credit, and the restart from zero after a reset in mid-purchase. Only the bench's scenarios show these, by checking the outputs against sequences worked out by hand.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int COIN_W     = 2;
    localparam int UNIT_CENTS = 5;
    localparam int VEND_CENTS = 20;
    localparam int BIG_CENTS  = 25;
    localparam int THRESH_U   = VEND_CENTS / UNIT_CENTS;
    localparam int MAX_COIN_U = BIG_CENTS / UNIT_CENTS;
    localparam int CREDIT_W   = $clog2(THRESH_U);
    localparam int SUM_W      = $clog2(THRESH_U + MAX_COIN_U);
    localparam int CHANGE_W   = $clog2(MAX_COIN_U);

    typedef enum logic [COIN_W-1:0] {
        COIN_NONE    = 2'b00,
        COIN_NICKEL  = 2'b01,
        COIN_DIME    = 2'b10,
        COIN_QUARTER = 2'b11
    } coin_e;

    typedef logic [CREDIT_W-1:0] credit_t;
    typedef logic [SUM_W-1:0]    sum_t;
    typedef logic [CHANGE_W-1:0] change_t;

    typedef struct packed {
        logic  present;
        sum_t  units;
    } coin_val_t;

    typedef struct packed {
        logic    vend;
        change_t change;
        credit_t next_credit;
    } step_t;

    function automatic sum_t coin_units(coin_e c);
        case (c)
            COIN_NICKEL:  return sum_t'(5  / UNIT_CENTS);
            COIN_DIME:    return sum_t'(10 / UNIT_CENTS);
            COIN_QUARTER: return sum_t'(BIG_CENTS / UNIT_CENTS);
            default:      return '0;
        endcase
    endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic [COIN_W-1:0] coin_i,
    output coin_val_t         val_o
);
    coin_e code;

    always_comb begin
        code          = coin_e'(coin_i);
        val_o.present = (code != COIN_NONE);
        val_o.units   = coin_units(code);
    end
endmodule

// File: rtl/vend_step_logic.sv
module vend_step_logic
    import vend_pkg::*;
(
    input  logic      rst,
    input  credit_t   credit_i,
    input  coin_val_t coin_i,
    output step_t     step_o
);
    sum_t total;
    logic crossing;

    always_comb begin
        total    = sum_t'(credit_i) + coin_i.units;
        crossing = coin_i.present && (total >= sum_t'(THRESH_U));

        step_o.vend        = 1'b0;
        step_o.change      = '0;
        step_o.next_credit = credit_i;

        if (rst) begin
            step_o.next_credit = '0;
        end else if (crossing) begin
            step_o.vend        = 1'b1;
            step_o.change      = change_t'(total - sum_t'(THRESH_U));
            step_o.next_credit = '0;
        end else if (coin_i.present) begin
            step_o.next_credit = credit_t'(total);
        end
    end
endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  credit_t d_i,
    output credit_t q_o
);
    always_ff @(posedge clk) begin
        q_o <= d_i;
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [COIN_W-1:0]   coin_i,
    output logic                vend_o,
    output logic [CHANGE_W-1:0] change_o
);
    coin_val_t coin_val;
    step_t     step;
    credit_t   credit_q;

    vend_coin_decode u_decode (
        .coin_i (coin_i),
        .val_o  (coin_val)
    );

    vend_step_logic u_step (
        .rst      (rst),
        .credit_i (credit_q),
        .coin_i   (coin_val),
        .step_o   (step)
    );

    vend_credit_reg u_credit (
        .clk (clk),
        .d_i (step.next_credit),
        .q_o (credit_q)
    );

    assign vend_o   = step.vend;
    assign change_o = step.change;
endmodule

// File: rtl/vend_ctrl_checker.sv
module vend_ctrl_checker
    import vend_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [COIN_W-1:0]   coin_i,
    input logic                vend_o,
    input logic [CHANGE_W-1:0] change_o,
    input logic [CREDIT_W-1:0] credit_q
);
    a_r6_none_is_silent: assert property (@(posedge clk) disable iff (rst)
        (coin_i == 2'b00) |-> (!vend_o && change_o == '0));

    a_r9_quarter_always_vends: assert property (@(posedge clk) disable iff (rst)
        (coin_i == 2'b11) |-> vend_o);

    a_r8_change_needs_vend: assert property (@(posedge clk) disable iff (rst)
        (change_o != '0) |-> vend_o);

    a_r4_change_bounded: assert property (@(posedge clk) disable iff (rst)
        vend_o |-> (change_o <= CHANGE_W'(MAX_COIN_U - 1)));

    a_r5_clear_after_vend: assert property (@(posedge clk) disable iff (rst)
        vend_o |=> (credit_q == '0));

    a_r7_reset_quiet: assert property (@(posedge clk)
        rst |-> (!vend_o && change_o == '0));
endmodule

bind vend_ctrl vend_ctrl_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .coin_i   (coin_i),
    .vend_o   (vend_o),
    .change_o (change_o),
    .credit_q (credit_q)
);

// File: tb/vend_ctrl_test.sv
`timescale 1ns/1ps
module vend_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] coin = 2'b00;
    logic       vend;
    logic [2:0] change;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vend_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .coin_i   (coin),
        .vend_o   (vend),
        .change_o (change)
    );

    // entry: {coin[1:0], vend, change[2:0]}
    localparam int NV = 24;
    localparam logic [5:0] VEC [NV] = '{
        {2'd1, 1'b0, 3'd0}, {2'd1, 1'b0, 3'd0}, {2'd1, 1'b0, 3'd0}, {2'd1, 1'b1, 3'd0},
        {2'd2, 1'b0, 3'd0}, {2'd2, 1'b1, 3'd0},
        {2'd3, 1'b1, 3'd1},
        {2'd1, 1'b0, 3'd0}, {2'd3, 1'b1, 3'd2},
        {2'd2, 1'b0, 3'd0}, {2'd3, 1'b1, 3'd3},
        {2'd1, 1'b0, 3'd0}, {2'd2, 1'b0, 3'd0}, {2'd3, 1'b1, 3'd4},
        {2'd2, 1'b0, 3'd0}, {2'd0, 1'b0, 3'd0}, {2'd0, 1'b0, 3'd0}, {2'd2, 1'b1, 3'd0},
        {2'd1, 1'b0, 3'd0}, {2'd2, 1'b0, 3'd0}, {2'd2, 1'b1, 3'd1},
        {2'd2, 1'b0, 3'd0}, {2'd1, 1'b0, 3'd0}, {2'd1, 1'b1, 3'd0}
    };

    // drive on falling edge, sample 5 ns later (outputs are combinational)
    task automatic step(input logic [1:0] c, input logic ev, input logic [2:0] ec,
                        input string tag);
        @(negedge clk);
        coin = c;
        #5;
        n_checks++;
        if (vend !== ev || change !== ec) begin
            n_fail++;
            $display("FAIL %s: coin=%0d vend=%0b change=%0d expected vend=%0b change=%0d",
                     tag, c, vend, change, ev, ec);
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: silent under reset even with a quarter present
        rst = 1'b1;
        step(2'd3, 1'b0, 3'd0, "R7 reset with quarter");
        step(2'd2, 1'b0, 3'd0, "R7 reset with dime");
        @(negedge clk);
        rst  = 1'b0;
        coin = 2'b00;

        // table: R1 coding, R2 accumulate, R3 same-cycle vend, R4 change,
        // R5 restart at zero, R6 idle code, R8 single pulse, R9 quarter
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5:4], VEC[i][3], VEC[i][2:0], "R1 R2 R3 R4 R5 R6 R8 R9 table");
        end

        // R7: reset mid-purchase clears credit
        step(2'd2, 1'b0, 3'd0, "R2 build credit 10");
        step(2'd1, 1'b0, 3'd0, "R2 build credit 15");
        @(negedge clk);
        rst = 1'b1;
        step(2'd3, 1'b0, 3'd0, "R7 reset gates quarter");
        @(negedge clk);
        rst  = 1'b0;
        coin = 2'b00;
        step(2'd2, 1'b0, 3'd0, "R7 credit zero after reset");
        step(2'd2, 1'b1, 3'd0, "R3 vend at exactly 20");

        // R6: idle cycles keep credit 15 intact
        step(2'd2, 1'b0, 3'd0, "R2 credit 10");
        step(2'd1, 1'b0, 3'd0, "R2 credit 15");
        step(2'd0, 1'b0, 3'd0, "R6 idle no output");
        step(2'd0, 1'b0, 3'd0, "R6 idle no output");
        step(2'd1, 1'b1, 3'd0, "R6 credit kept through idle");
        // R8: coin right after vend starts fresh, no second pulse
        step(2'd1, 1'b0, 3'd0, "R8 no repeat pulse");
        step(2'd0, 1'b0, 3'd0, "R8 idle after");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule